// File: doc/BRIEF.md
# Flash Access Cycle Sequencer

This block times each read or programming write that a bus master makes to an on-chip flash array. The master presents a request (address, direction, width, write data) and the sequencer runs one access cycle. While the cycle lasts it holds the active-low chip enable low. It also holds output enable low for a read or write enable low for a write. It pulses an address-latch strobe and an equalize strobe, each at a clock offset of its own. It ends the cycle with a one-clock ready pulse. On that pulse a read also returns its data, trimmed to the requested width.

Three configuration inputs set the timing, and none depends on another: the wait count, the latch-strobe offset and the equalize-strobe offset. All three are captured when a request is accepted, so the whole cycle uses the values that were present at that moment. The master can abort a running cycle on any clock. The abort leaves no trace, so the next cycle has exactly the same timing as one that follows a normally completed access. A new request can be taken on the clock in which the previous cycle completes or is aborted.

Top module: `flash_cycle_seq`

## Requirements
- R1: After reset, and while no access is running, `fl_ce_n`, `fl_we_n` and `fl_oe_n` are 1 and `fl_ale`, `fl_eq` and `done` are 0.
- R2: An accepted access makes `fl_ce_n` 0 for exactly `W`+1 clocks, where `W` is `cfg_wait` sampled at acceptance. Those clocks are access cycle indices 0..`W`, and index 0 is the clock after the accepting edge.
- R3: Throughout an access, `fl_oe_n` is 0 when `req_write`=0 (read) and `fl_we_n` is 0 when `req_write`=1 (write). The opposite strobe stays at 1.
- R4: `done` is 1 for one clock at access index `W`, unless `abort` is high in that same clock.
- R5: `fl_ale` is 1 only at access index equal to `cfg_ale_ofs` (0..3, sampled at acceptance). If that offset exceeds `W`, `fl_ale` stays 0.
- R6: `fl_eq` is 1 only at access index equal to `cfg_eq_ofs` (0..3, sampled at acceptance). If that offset exceeds `W`, `fl_eq` stays 0.
- R7: Changes on `cfg_wait`, `cfg_ale_ofs` or `cfg_eq_ofs` during a running access do not alter that access's timing.
- R8: For a read, `req_wide`=1 selects 64 bits: `rdata` equals `fl_rdata` on the `done` clock. `req_wide`=0 selects 32 bits: `rdata[63:32]` is 0 and `rdata[31:0]` equals `fl_rdata[31:0]`. Outside a read's `done` clock `rdata` is 0. `fl_wide` shows the latched width during the access.
- R9: For a write, `req_wide`=1 selects 32 bits: `fl_wdata` equals `req_wdata`. `req_wide`=0 selects 16 bits: `fl_wdata[31:16]` is 0. For reads `fl_wdata` is 0. `fl_addr` holds the latched `req_addr` during the access.
- R10: `abort` high during a running access ends it. On the next clock every strobe is inactive and no `done` appears, unless a new request was accepted on that edge.
- R11: `req_ready` is 1 when idle, at access index `W`, or while `abort` is high. A request with `req_valid`=1 and `req_ready`=1 is accepted, and its index 0 follows directly, with no idle gap.
- R12: A request presented while `req_ready` is 0 is ignored and does not change the running access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = programming write, 0 = read |
| req_wide | input | 1 | Width select (read 64/32, write 32/16) |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W/2 | Write data |
| abort | input | 1 | Cancel the running access |
| req_ready | output | 1 | Request is taken this clock if valid |
| cfg_wait | input | WAIT_W | Wait count W |
| cfg_ale_ofs | input | OFS_W | Address-latch strobe offset |
| cfg_eq_ofs | input | OFS_W | Equalize strobe offset |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_we_n | output | 1 | Write enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_ale | output | 1 | Address-latch strobe |
| fl_eq | output | 1 | Equalize strobe |
| fl_addr | output | ADDR_W | Latched address to the array |
| fl_wdata | output | DATA_W/2 | Width-trimmed write data |
| fl_wide | output | 1 | Latched width select |
| fl_rdata | input | DATA_W | Read data from the array |
| done | output | 1 | Access complete |
| rdata | output | DATA_W | Width-trimmed read data |

## Verification
A wrong cycle index or a wrong latched wait count moves `done`, and with it the end of chip enable, to the wrong clock. This is visible within the first access that uses a nonzero wait. A corrupted latched offset moves `fl_ale` or `fl_eq` within that same access. A stale active flag after an abort leaves chip enable low on the following clock, so the error shows one cycle after the abort. A latched op that is wrong swaps the two enables, or changes the width trim on `rdata` and `fl_wdata`, from index 0 of the access.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [1:0] {
    OP_RD_NARROW = 2'b00,
    OP_RD_WIDE   = 2'b01,
    OP_WR_NARROW = 2'b10,
    OP_WR_WIDE   = 2'b11
  } op_e;

  function automatic op_e op_of(input logic is_wr, input logic is_wide);
    return op_e'({is_wr, is_wide});
  endfunction

  function automatic logic op_is_write(input op_e op);
    return op[1];
  endfunction

  function automatic logic op_is_wide(input op_e op);
    return op[0];
  endfunction
endpackage

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl #(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              abort,
  input  logic [WAIT_W-1:0] cfg_wait,
  output logic              active,
  output logic [WAIT_W-1:0] idx,
  output logic              last,
  output logic              accept,
  output logic              req_ready
);
  logic              active_d;
  logic [WAIT_W-1:0] idx_d, wait_q, wait_d;

  always_comb begin
    last      = active && (idx == wait_q);
    req_ready = !active || last || abort;
    accept    = req_valid && req_ready;
    active_d  = accept || (active && !last && !abort);
    wait_d    = accept ? cfg_wait : wait_q;
    if (accept)        idx_d = '0;
    else if (active_d) idx_d = idx + 1'b1;
    else               idx_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
      wait_q <= '0;
    end else begin
      active <= active_d;
      idx    <= idx_d;
      if (accept) wait_q <= wait_d;
    end
  end

  p_idx_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (idx <= wait_q));
  p_abort_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (active && abort && !req_valid) |=> !active);
  p_accept_starts_r11: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (active && idx == '0));
  p_busy_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !last && !abort) |=> (active && idx == $past(idx) + 1'b1));
endmodule

// File: rtl/flash_seq_strobe.sv
module flash_seq_strobe
  import flash_seq_pkg::*;
#(
  parameter int WAIT_W = 4,
  parameter int OFS_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              active,
  input  logic [WAIT_W-1:0] idx,
  input  logic              last,
  input  logic              abort,
  input  op_e               op,
  input  logic [OFS_W-1:0]  cfg_ale_ofs,
  input  logic [OFS_W-1:0]  cfg_eq_ofs,
  output logic              ce_n,
  output logic              we_n,
  output logic              oe_n,
  output logic              ale,
  output logic              eq,
  output logic              ready
);
  localparam int CMP_W = (WAIT_W > OFS_W) ? WAIT_W : OFS_W;

  logic [OFS_W-1:0] ale_q, eq_q;
  logic [CMP_W-1:0] idx_x, ale_x, eq_x;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_q <= '0;
      eq_q  <= '0;
    end else if (accept) begin
      ale_q <= cfg_ale_ofs;
      eq_q  <= cfg_eq_ofs;
    end
  end

  always_comb begin
    idx_x = CMP_W'(idx);
    ale_x = CMP_W'(ale_q);
    eq_x  = CMP_W'(eq_q);
    ce_n  = !active;
    we_n  = !(active && op_is_write(op));
    oe_n  = !(active && !op_is_write(op));
    ale   = active && (idx_x == ale_x);
    eq    = active && (idx_x == eq_x);
    ready = last && !abort;
  end

  p_enable_in_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n || !oe_n) |-> !ce_n);
  p_strobe_in_ce_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ale || eq) |-> !ce_n);
  p_ready_in_ce_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !ce_n);
endmodule

// File: rtl/flash_seq_datapath.sv
module flash_seq_datapath
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accept,
  input  logic                active,
  input  logic                ready,
  input  logic                req_write,
  input  logic                req_wide,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W/2-1:0] req_wdata,
  input  logic [DATA_W-1:0]   fl_rdata,
  output op_e                 op,
  output logic [ADDR_W-1:0]   fl_addr,
  output logic [DATA_W/2-1:0] fl_wdata,
  output logic                fl_wide,
  output logic [DATA_W-1:0]   rdata
);
  localparam int HALF_W = DATA_W / 2;
  localparam int QTR_W  = DATA_W / 4;

  op_e               op_d;
  logic [HALF_W-1:0] wdata_d;

  always_comb begin
    op_d = op_of(req_write, req_wide);
    if (!req_write)    wdata_d = '0;
    else if (req_wide) wdata_d = req_wdata;
    else               wdata_d = {{(HALF_W-QTR_W){1'b0}}, req_wdata[QTR_W-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op       <= OP_RD_NARROW;
      fl_addr  <= '0;
      fl_wdata <= '0;
    end else if (accept) begin
      op       <= op_d;
      fl_addr  <= req_addr;
      fl_wdata <= wdata_d;
    end
  end

  always_comb begin
    fl_wide = op_is_wide(op);
    if (!ready || op_is_write(op)) rdata = '0;
    else if (op_is_wide(op))       rdata = fl_rdata;
    else                           rdata = {{HALF_W{1'b0}}, fl_rdata[HALF_W-1:0]};
  end

  p_wr_narrow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && op == OP_WR_NARROW) |-> (fl_wdata[HALF_W-1:QTR_W] == '0));
  p_rd_narrow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_RD_NARROW) |-> (rdata[DATA_W-1:HALF_W] == '0));
  p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !$past(accept)) |-> $stable(fl_addr));
endmodule

// File: rtl/flash_cycle_seq.sv
module flash_cycle_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 64,
  parameter int WAIT_W = 4,
  parameter int OFS_W  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic                req_wide,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W/2-1:0] req_wdata,
  input  logic                abort,
  output logic                req_ready,
  input  logic [WAIT_W-1:0]   cfg_wait,
  input  logic [OFS_W-1:0]    cfg_ale_ofs,
  input  logic [OFS_W-1:0]    cfg_eq_ofs,
  output logic                fl_ce_n,
  output logic                fl_we_n,
  output logic                fl_oe_n,
  output logic                fl_ale,
  output logic                fl_eq,
  output logic [ADDR_W-1:0]   fl_addr,
  output logic [DATA_W/2-1:0] fl_wdata,
  output logic                fl_wide,
  input  logic [DATA_W-1:0]   fl_rdata,
  output logic                done,
  output logic [DATA_W-1:0]   rdata
);
  logic [1:0]        rst_sync;
  logic              srst_n;
  logic              active, last, accept;
  logic [WAIT_W-1:0] idx;
  op_e               op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign srst_n = rst_sync[1];

  flash_seq_ctrl #(.WAIT_W(WAIT_W)) u_ctrl (
    .clk(clk), .rst_n(srst_n), .req_valid(req_valid), .abort(abort),
    .cfg_wait(cfg_wait), .active(active), .idx(idx), .last(last),
    .accept(accept), .req_ready(req_ready)
  );

  flash_seq_strobe #(.WAIT_W(WAIT_W), .OFS_W(OFS_W)) u_strobe (
    .clk(clk), .rst_n(srst_n), .accept(accept), .active(active), .idx(idx),
    .last(last), .abort(abort), .op(op), .cfg_ale_ofs(cfg_ale_ofs),
    .cfg_eq_ofs(cfg_eq_ofs), .ce_n(fl_ce_n), .we_n(fl_we_n), .oe_n(fl_oe_n),
    .ale(fl_ale), .eq(fl_eq), .ready(done)
  );

  flash_seq_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(srst_n), .accept(accept), .active(active), .ready(done),
    .req_write(req_write), .req_wide(req_wide), .req_addr(req_addr),
    .req_wdata(req_wdata), .fl_rdata(fl_rdata), .op(op), .fl_addr(fl_addr),
    .fl_wdata(fl_wdata), .fl_wide(fl_wide), .rdata(rdata)
  );

  p_abort_quiet_r10: assert property (@(posedge clk) disable iff (!srst_n)
    (!fl_ce_n && abort && !accept) |=> (fl_ce_n && fl_we_n && fl_oe_n && !fl_ale && !fl_eq && !done));
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!srst_n)
    fl_ce_n |-> (fl_we_n && fl_oe_n && !fl_ale && !fl_eq && !done));
  p_done_ends_r4: assert property (@(posedge clk) disable iff (!srst_n)
    (done && !accept) |=> fl_ce_n);
endmodule

// File: tb/sim_flash_cycle_seq.sv
module sim_flash_cycle_seq;
  localparam int AW = 20, DW = 64, WW = 4, OW = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_write, req_wide, abort;
  logic [AW-1:0] req_addr;
  logic [DW/2-1:0] req_wdata;
  logic [WW-1:0] cfg_wait;
  logic [OW-1:0] cfg_ale_ofs, cfg_eq_ofs;
  logic [DW-1:0] fl_rdata;
  logic req_ready, fl_ce_n, fl_we_n, fl_oe_n, fl_ale, fl_eq, fl_wide, done;
  logic [AW-1:0] fl_addr;
  logic [DW/2-1:0] fl_wdata;
  logic [DW-1:0] rdata;

  always #5 clk = ~clk;

  flash_cycle_seq #(.ADDR_W(AW), .DATA_W(DW), .WAIT_W(WW), .OFS_W(OW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
    .abort(abort), .req_ready(req_ready), .cfg_wait(cfg_wait),
    .cfg_ale_ofs(cfg_ale_ofs), .cfg_eq_ofs(cfg_eq_ofs), .fl_ce_n(fl_ce_n),
    .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n), .fl_ale(fl_ale), .fl_eq(fl_eq),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_wide(fl_wide),
    .fl_rdata(fl_rdata), .done(done), .rdata(rdata)
  );

  int n_run = 0, n_fail = 0, n_cyc = 0;
  bit finished = 0;

  // behavioural reference state
  bit m_act = 0, m_wr = 0, m_wide = 0;
  int m_idx = 0, m_w = 0, m_ale = 0, m_eq = 0;
  logic [AW-1:0] m_addr = '0;
  logic [DW/2-1:0] m_wdata = '0;

  task automatic chk(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s cycle %0d: actual %h expected %h", tag, what, n_cyc, act, exp);
    end
  endtask

  // compare outputs at the current inputs, then advance one clock
  task automatic cyc();
    bit e_last, e_rdy, e_done;
    logic [DW-1:0] e_rd;
    fl_rdata = {32'h9E37_79B9 * n_cyc, 32'h7F4A_7C15 ^ (n_cyc * 32'h0101_0101)};
    #2;
    e_last = m_act && (m_idx == m_w);
    e_rdy  = !m_act || e_last || abort;
    e_done = e_last && !abort;
    e_rd   = (!e_done || m_wr) ? '0 : (m_wide ? fl_rdata : {32'h0, fl_rdata[31:0]});
    chk(m_act ? "R2" : "R1", "ce_n", DW'(fl_ce_n), DW'(!m_act));
    chk("R3", "oe_n", DW'(fl_oe_n), DW'(!(m_act && !m_wr)));
    chk("R3", "we_n", DW'(fl_we_n), DW'(!(m_act && m_wr)));
    chk("R5", "ale", DW'(fl_ale), DW'(m_act && m_idx == m_ale));
    chk("R6", "eq", DW'(fl_eq), DW'(m_act && m_idx == m_eq));
    chk(abort ? "R10" : "R4", "done", DW'(done), DW'(e_done));
    chk("R11", "req_ready", DW'(req_ready), DW'(e_rdy));
    chk("R8", "rdata", rdata, e_rd);
    if (m_act) begin
      chk("R8", "fl_wide", DW'(fl_wide), DW'(m_wide));
      chk("R9", "fl_addr", DW'(fl_addr), DW'(m_addr));
      chk("R9", "fl_wdata", DW'(fl_wdata),
          DW'(!m_wr ? 32'h0 : (m_wide ? m_wdata : {16'h0, m_wdata[15:0]})));
    end
    // R7 R12: state only changes through the accept rule below
    if (m_act) begin
      if (abort || e_last) m_act = 0;
      else m_idx++;
    end
    if (req_valid && e_rdy) begin
      m_act = 1; m_idx = 0; m_wr = req_write; m_wide = req_wide;
      m_w = cfg_wait; m_ale = cfg_ale_ofs; m_eq = cfg_eq_ofs;
      m_addr = req_addr; m_wdata = req_wdata;
    end
    @(posedge clk);
    n_cyc++;
    @(negedge clk);
  endtask

  task automatic set_req(bit wr, bit wide, int w, int a, int e);
    req_valid = 1; req_write = wr; req_wide = wide;
    req_addr = AW'(32'h3_0000 + n_cyc * 8); req_wdata = 32'hA5C3_0000 + n_cyc;
    cfg_wait = WW'(w); cfg_ale_ofs = OW'(a); cfg_eq_ofs = OW'(e);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      req_valid = 0; cyc();
    end
  endtask

  task automatic one(bit wr, bit wide, int w, int a, int e);
    set_req(wr, wide, w, a, e); cyc(); req_valid = 0;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_valid = 0; req_write = 0; req_wide = 0; abort = 0;
    req_addr = '0; req_wdata = '0; cfg_wait = '0; cfg_ale_ofs = '0; cfg_eq_ofs = '0;
    fl_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(4);                                     // R1 reset/idle state
    one(0, 0, 3, 1, 2); idle(5);                 // R2 R3 R4 R5 R6 narrow read
    one(0, 1, 5, 0, 3);                          // R8 wide read
    cfg_wait = 1; cfg_ale_ofs = 3; cfg_eq_ofs = 1; idle(7);   // R7 cfg changed mid-access
    one(1, 0, 2, 2, 0); idle(4);                 // R9 narrow write
    one(1, 1, 2, 1, 1); idle(4);                 // R9 wide write
    one(0, 1, 1, 3, 2); idle(3);                 // R5 R6 offsets beyond wait
    for (int k = 0; k < 3; k++) begin            // R11 back-to-back, wait 0
      set_req(k[0], 1, 0, 0, 1); cyc();
    end
    req_valid = 0; idle(2);
    one(0, 1, 4, 2, 3);                          // R10 abort with new request
    cyc(); abort = 1; set_req(1, 1, 3, 1, 2); cyc(); abort = 0; req_valid = 0;
    idle(5);
    one(0, 0, 6, 1, 1); cyc();                   // R10 abort then idle
    abort = 1; cyc(); abort = 0; idle(3);
    one(1, 0, 2, 0, 2); cyc(); cyc();            // R10 abort on last index
    abort = 1; cyc(); abort = 0; idle(2);
    one(0, 0, 5, 0, 0);                          // R12 request while busy
    for (int k = 0; k < 7; k++) begin
      set_req(1, 1, 2, 3, 1); cyc();
    end
    req_valid = 0; idle(5);
    abort = 1; idle(2); abort = 0;               // R10 abort while idle
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule